// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies an accumulator value by an operand using one add-and-shift step per clock. A start strobe captures both factors. The unit then works through one multiplier bit per cycle, lowest bit first. When the run ends, the upper part of the product is in the accumulator output and the lower part is in a narrower extension register.

The extension register is one bit narrower than the accumulator. Both registers are cleared when a run begins. The product is exact only when the top bit of each factor is zero, so at the default width the unit acts as an 11-bit by 11-bit unsigned multiplier. A busy level covers the whole run, and a single-cycle done pulse marks the result as ready. Results stay in place until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: After reset, acc_o and ext_o are zero, and busy_o and done_o are low.
- R2: A start_i sampled high at a clock edge while busy_o is low is accepted, and busy_o is high from the following cycle.
- R3: busy_o stays high for exactly DATA_W (12) cycles after an accepted start, one cycle per multiplier bit.
- R4: done_o rises in the cycle right after busy_o falls, is high for one cycle only, and is never high together with busy_o.
- R5: When bit DATA_W-1 of both acc_i and opnd_i is zero, {acc_o, ext_o} equals acc_i * opnd_i at done_o. The low DATA_W-1 product bits are in ext_o and the remaining bits are in acc_o.
- R6: In the first busy cycle after an accepted start, both acc_o and ext_o read zero.
- R7: start_i is ignored while busy_o is high. The running product and its cycle count are not affected.
- R8: While busy_o is low and no start is accepted, acc_o and ext_o hold their values.
- R9: For any operands, including those with bit DATA_W-1 set, {acc_o, ext_o} equals (acc_i * opnd_i) modulo 2^(2*DATA_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| acc_i | input | DATA_W | Accumulator factor (multiplier) |
| opnd_i | input | DATA_W | Memory operand factor (multiplicand) |
| acc_o | output | DATA_W | Accumulator register: upper product bits |
| ext_o | output | DATA_W-1 | Extension register: lower product bits |
| busy_o | output | 1 | High while the multiply runs |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench builds the block at its default DATA_W of 12. This keeps the accumulator and extension register at 12 and 11 bits, and the run at 12 steps.

At this width the full range of both factors can be reached:
- the largest exact case, 2047 by 2047;
- factors with the top bit set, where the product wraps modulo 2^23.

These cases exercise the carry out of the upper partial sum and the unshifted final step. A start issued in the middle of a run checks that the step count and the result are not disturbed.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int unsigned DEF_DATA_W = 12;

  typedef struct packed {
    logic load;  // capture factors, clear partial product
    logic step;  // one add-and-shift iteration
    logic last;  // final iteration: add without shifting
  } step_ctrl_t;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output step_ctrl_t ctrl_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_comb begin
    ctrl_o.load = start_i && !busy_q;
    ctrl_o.step = busy_q;
    ctrl_o.last = busy_q && (cnt_q == LAST_IT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ctrl_o.load) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (ctrl_o.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
  import smul_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_ctrl_t        ctrl_i,
  input  logic [DATA_W-1:0] mplier_i,
  input  logic [DATA_W-1:0] mcand_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-2:0] ext_o
);
  localparam int unsigned EXT_W = DATA_W - 1;

  logic [DATA_W-1:0] hi_q, mcand_q, mplier_q;
  logic [EXT_W-1:0]  ext_q;
  logic [DATA_W:0]   sum;

  // carry kept in sum[DATA_W]; it shifts into hi on non-final steps
  assign sum = {1'b0, hi_q} + (mplier_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      ext_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (ctrl_i.load) begin
      hi_q     <= '0;
      ext_q    <= '0;
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
    end else if (ctrl_i.step) begin
      mplier_q <= mplier_q >> 1;
      if (ctrl_i.last) begin
        // top multiplier bit weighs 2^EXT_W: add in place, carry dropped
        hi_q <= sum[DATA_W-1:0];
      end else begin
        hi_q  <= sum[DATA_W:1];
        ext_q <= {sum[0], ext_q[EXT_W-1:1]};
      end
    end
  end

  assign hi_o  = hi_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/seq_mul.sv
module seq_mul
  import smul_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-2:0] ext_o,
  output logic              busy_o,
  output logic              done_o
);
  step_ctrl_t ctrl;

  smul_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ctrl_o  (ctrl),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  smul_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl),
    .mplier_i (acc_i),
    .mcand_i  (opnd_i),
    .hi_o     (acc_o),
    .ext_o    (ext_o)
  );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-2:0] ext_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int unsigned RUN_W = $clog2(DATA_W + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (start_i && !busy_o) run_q <= '0;
    else if (busy_o)            run_q <= run_q + 1'b1;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R2
  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == RUN_W'(DATA_W)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R4
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R4
  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> (ext_o == '0) && (acc_o == '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(acc_o) && $stable(ext_o)); // R8
endmodule

bind seq_mul smul_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .acc_o   (acc_o),
  .ext_o   (ext_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/sim_seq_mul.sv
module sim_seq_mul;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned PROD_W = 2 * DATA_W - 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] acc_i = '0;
  logic [DATA_W-1:0] opnd_i = '0;
  logic [DATA_W-1:0] acc_o;
  logic [DATA_W-2:0] ext_o;
  logic              busy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seq_mul #(.DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .acc_o(acc_o), .ext_o(ext_o), .busy_o(busy_o),
    .done_o(done_o)
  );

  function automatic logic [PROD_W-1:0] ref_prod(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] full;
    full = a * b;
    return full[PROD_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_mul(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input bit poke);
    logic [PROD_W-1:0] exp_p, got;
    int cycles;
    string rq;
    exp_p = ref_prod(a, b);
    rq = (a[DATA_W-1] || b[DATA_W-1]) ? "R9" : "R5";
    @(negedge clk);
    acc_i = a; opnd_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", longint'(busy_o), 1);
    chk(acc_o === '0 && ext_o === '0, "R6 cleared at start", longint'({acc_o, ext_o}), 0);
    cycles = 0;
    while (busy_o === 1'b1 && cycles < 100) begin
      if (poke && cycles == 3) begin
        start_i = 1'b1; acc_i = ~a; opnd_i = ~b;  // R7: must be ignored
      end else start_i = 1'b0;
      cycles++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(cycles == DATA_W, poke ? "R7 cycle count" : "R3 busy length", cycles, DATA_W);
    chk(done_o === 1'b1, "R4 done after busy", longint'(done_o), 1);
    got = {acc_o, ext_o};
    chk(got === exp_p, poke ? "R7 result" : rq, longint'(got), longint'(exp_p));
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R4 single pulse", longint'({busy_o, done_o}), 0);
    acc_i = ~acc_i; opnd_i = opnd_i + 1'b1;
    repeat (2) @(negedge clk);
    chk({acc_o, ext_o} === exp_p, "R8 hold idle", longint'({acc_o, ext_o}), longint'(exp_p));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd5021);
    repeat (3) @(negedge clk);
    chk(acc_o === '0 && ext_o === '0, "R1 results", longint'({acc_o, ext_o}), 0);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", longint'({busy_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    do_mul(12'd0, 12'd1234, 1'b0);
    do_mul(12'd2047, 12'd2047, 1'b0);
    do_mul(12'd1, 12'd2047, 1'b0);
    do_mul(12'd2047, 12'd1, 1'b0);
    do_mul(12'd1365, 12'd682, 1'b1);
    do_mul(12'd4095, 12'd4095, 1'b0);
    do_mul(12'd2048, 12'd3, 1'b0);
    do_mul(12'd5, 12'd2049, 1'b0);
    for (int i = 0; i < 60; i++) begin
      logic [DATA_W-1:0] a, b;
      a = DATA_W'($urandom);
      b = DATA_W'($urandom);
      if (i < 40) begin a[DATA_W-1] = 1'b0; b[DATA_W-1] = 1'b0; end
      do_mul(a, b, (i % 9) == 4);
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule